// File: doc/BRIEF.md
# Sixty-LED Ring Row Scanner

This block scans a ring of sixty LEDs that is wired as eight multiplexed rows: seven rows of eight LEDs and a last, short row of four. It shows one row at a time. For that row it drives an eight-bit pattern, one bit per LED. It also drives strobes to an external one-hot row-select counter: a step pulse moves the counter to the next row, and a reset pulse returns it to the first row after the eighth. Because only one row is lit at a time, no more than eight LEDs are ever on together.

The block holds two banks of eight row registers. One bank holds the clockwise rendering of a pattern and the other the counter-clockwise rendering. A direction input picks which bank is scanned. Software or a pattern engine loads the registers through a simple write port. The block samples the direction only when a frame opens, so a frame never mixes the two banks. While a strobe is high, the row data is forced to zero, so the row being left never shows the next row's pattern.

The scan is paced by a scan-rate enable. A full frame takes sixteen enable ticks, so the enable rate must be at least sixteen times the refresh rate wanted. For example, a 2 kHz enable gives a 125 Hz refresh, well clear of visible flicker.

The controller is a three-state machine:
- ST_CLEAR: the counter-reset strobe is high and the data is blank.
- ST_SHOW: a row is displayed.
- ST_STEP: the counter-step strobe is high and the data is blank.

Its transitions are:
- T_OPEN: ST_CLEAR to ST_SHOW. It latches the direction and selects row 0.
- T_STEP: ST_SHOW to ST_STEP, taken on any row but the last.
- T_NEXT: ST_STEP to ST_SHOW. It advances the row index by one.
- T_WRAP: ST_SHOW on the last row back to ST_CLEAR.

A transition is taken only on a clock where the scan enable is high.

Top module: `ring_row_scanner`

## Requirements
- R1: After reset the block is in ST_CLEAR: `cnt_reset` is 1, `cnt_step` is 0, `row_data` is 0, `row_idx` is 0, and all sixteen row registers read as zero.
- R2: The state and `row_idx` change only on a clock where `scan_en` is 1. With `scan_en` at 0 and no write, every output holds its value.
- R3: The states cycle in a fixed order: ST_CLEAR, then row 0 shown, then step, then row 1 shown, and so on until row 7 is shown, then ST_CLEAR again. A frame is 16 enable ticks. `cnt_reset` rises only after row 7 has been shown.
- R4: `cnt_step` is 1 exactly while in ST_STEP, which happens seven times per frame. `cnt_step` and `cnt_reset` are never 1 together.
- R5: `row_data` is 0 whenever `cnt_step` or `cnt_reset` is 1.
- R6: In ST_SHOW on row r, `row_data` equals register r of the bank latched for the frame. Bank 0 (`dir_ccw`=0) is clockwise and bank 1 is counter-clockwise.
- R7: On row 7, bits 7:4 of `row_data` are always 0 and bits 3:0 come from the register.
- R8: `dir_ccw` is sampled only on T_OPEN. A change during a frame has no effect until the next frame opens.
- R9: With `wr_en`=1, `wr_data` is stored on that clock edge into the register selected by `wr_bank` (0 clockwise, 1 counter-clockwise) and `wr_row`. All other registers are unchanged. If that row is being shown from that bank, the new value appears on `row_data` the cycle after the edge.
- R10: `row_idx` increases by exactly one on each T_NEXT and returns to 0 on T_WRAP. `row_idx` is the row shown or just left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Scan-rate enable; one state step per high cycle |
| dir_ccw | input | 1 | Bank select for the next frame: 0 clockwise, 1 counter-clockwise |
| wr_en | input | 1 | Row register write strobe |
| wr_bank | input | 1 | Bank written: 0 clockwise, 1 counter-clockwise |
| wr_row | input | 3 | Row register index written |
| wr_data | input | 8 | Pattern written |
| row_data | output | 8 | Pattern of the active row, one bit per LED |
| cnt_step | output | 1 | Step strobe for the external row counter |
| cnt_reset | output | 1 | Reset strobe for the external row counter |
| row_idx | output | 3 | Index of the current row |

## Verification
The assertions watch, on every cycle, the properties that hold whatever is stored in the banks:
- the two strobes are never high together;
- the data is blank under either strobe;
- the short row's upper nibble stays zero;
- the row index steps by one as a step strobe ends;
- the counter reset rises only after the last row;
- nothing moves without the enable.

Some behaviours need the stored contents and the history of the inputs, and only the bench's reference model can show them:
- which bank a frame shows;
- that a mid-frame direction change is ignored;
- that writes land only in the addressed register and reach the display in the next cycle.

// File: rtl/ring_scan_pkg.sv
package ring_scan_pkg;

    // Controller states of the row scanner.
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,   // external counter held in reset, data blank
        ST_SHOW  = 2'd1,   // one row displayed
        ST_STEP  = 2'd2    // external counter stepped, data blank
    } scan_state_e;

    // Mask applied to the row data of a row that carries fewer LEDs.
    function automatic logic [7:0] width_mask(input int unsigned leds);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) begin
            m[i] = (i < leds);
        end
        return m;
    endfunction

endpackage

// File: rtl/ring_row_bank.sv
module ring_row_bank #(
    parameter int ROWS  = 8,
    parameter int ROW_W = 8,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [ROW_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_row,
    output logic [ROW_W-1:0] rd_data
);

    logic [ROW_W-1:0] regs_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[r] <= '0;
            end else if (wr_en && (wr_row == IDX_W'(r))) begin
                regs_q[r] <= wr_data;
            end
        end
    end

    assign rd_data = regs_q[rd_row];

endmodule

// File: rtl/ring_scan_fsm.sv
module ring_scan_fsm
    import ring_scan_pkg::*;
#(
    parameter int ROWS = 8,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             dir_in,
    output logic [IDX_W-1:0] row_q,
    output logic             frame_dir_q,
    output logic             step_o,
    output logic             clear_o,
    output logic             blank_o
);

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    scan_state_e state_q, state_d;
    logic [IDX_W-1:0] row_d;
    logic             dir_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        dir_d   = frame_dir_q;
        if (scan_en) begin
            unique case (state_q)
                ST_CLEAR: begin            // T_OPEN
                    state_d = ST_SHOW;
                    row_d   = '0;
                    dir_d   = dir_in;
                end
                ST_SHOW: begin
                    if (row_q == LAST_ROW) begin
                        state_d = ST_CLEAR; // T_WRAP
                        row_d   = '0;
                    end else begin
                        state_d = ST_STEP;  // T_STEP
                    end
                end
                ST_STEP: begin              // T_NEXT
                    state_d = ST_SHOW;
                    row_d   = row_q + IDX_W'(1);
                end
                default: begin
                    state_d = ST_CLEAR;
                    row_d   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_CLEAR;
            row_q       <= '0;
            frame_dir_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            row_q       <= row_d;
            frame_dir_q <= dir_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        step_o  = 1'b0;
        clear_o = 1'b0;
        blank_o = 1'b1;
        unique case (state_q)
            ST_CLEAR: clear_o = 1'b1;
            ST_SHOW:  blank_o = 1'b0;
            ST_STEP:  step_o  = 1'b1;
            default:  clear_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/ring_row_mux.sv
module ring_row_mux
    import ring_scan_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int ROW_W   = 8,
    parameter int SHORT_W = 4,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic [ROW_W-1:0] cw_data,
    input  logic [ROW_W-1:0] ccw_data,
    input  logic             sel_ccw,
    input  logic [IDX_W-1:0] row,
    input  logic             blank,
    output logic [ROW_W-1:0] row_data
);

    localparam logic [IDX_W-1:0] LAST_ROW   = IDX_W'(ROWS - 1);
    localparam logic [7:0]       SHORT_MASK = width_mask(SHORT_W);

    logic [ROW_W-1:0] picked;
    logic [ROW_W-1:0] mask;

    assign picked = sel_ccw ? ccw_data : cw_data;
    assign mask   = (row == LAST_ROW) ? SHORT_MASK[ROW_W-1:0] : '1;

    always_comb begin
        if (blank) begin
            row_data = '0;
        end else begin
            row_data = picked & mask;
        end
    end

endmodule

// File: rtl/ring_row_scanner.sv
module ring_row_scanner #(
    parameter int ROWS    = 8,
    parameter int ROW_W   = 8,
    parameter int SHORT_W = 4,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             dir_ccw,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_row,
    input  logic [ROW_W-1:0] wr_data,
    output logic [ROW_W-1:0] row_data,
    output logic             cnt_step,
    output logic             cnt_reset,
    output logic [IDX_W-1:0] row_idx
);

    localparam int BANKS = 2;

    logic [IDX_W-1:0] cur_row;
    logic             frame_ccw;
    logic             blank;
    logic [ROW_W-1:0] bank_rd [BANKS];

    ring_scan_fsm #(.ROWS(ROWS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_en     (scan_en),
        .dir_in      (dir_ccw),
        .row_q       (cur_row),
        .frame_dir_q (frame_ccw),
        .step_o      (cnt_step),
        .clear_o     (cnt_reset),
        .blank_o     (blank)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        ring_row_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_bank == 1'(b))),
            .wr_row  (wr_row),
            .wr_data (wr_data),
            .rd_row  (cur_row),
            .rd_data (bank_rd[b])
        );
    end

    ring_row_mux #(.ROWS(ROWS), .ROW_W(ROW_W), .SHORT_W(SHORT_W)) u_mux (
        .cw_data  (bank_rd[0]),
        .ccw_data (bank_rd[1]),
        .sel_ccw  (frame_ccw),
        .row      (cur_row),
        .blank    (blank),
        .row_data (row_data)
    );

    assign row_idx = cur_row;

endmodule

// File: rtl/ring_scan_checker.sv
module ring_scan_checker #(
    parameter int ROWS    = 8,
    parameter int ROW_W   = 8,
    parameter int SHORT_W = 4,
    localparam int IDX_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_en,
    input logic             wr_en,
    input logic [ROW_W-1:0] row_data,
    input logic             cnt_step,
    input logic             cnt_reset,
    input logic [IDX_W-1:0] row_idx
);

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt_step && cnt_reset));

    a_r5_blank_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step || cnt_reset) |-> (row_data == '0));

    a_r7_short_row: assert property (@(posedge clk) disable iff (!rst_n)
        (row_idx == LAST_ROW) |-> ((row_data >> SHORT_W) == '0));

    a_r10_row_advance: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnt_step) |-> (row_idx == $past(row_idx) + IDX_W'(1)));

    a_r3_reset_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_reset) |-> ($past(row_idx) == LAST_ROW));

    a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> ($stable(row_idx) && $stable(cnt_step) && $stable(cnt_reset)));

    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !wr_en) |=> $stable(row_data));

endmodule

bind ring_row_scanner ring_scan_checker #(
    .ROWS(ROWS), .ROW_W(ROW_W), .SHORT_W(SHORT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_en   (scan_en),
    .wr_en     (wr_en),
    .row_data  (row_data),
    .cnt_step  (cnt_step),
    .cnt_reset (cnt_reset),
    .row_idx   (row_idx)
);

// File: tb/tb_ring_row_scanner.sv
module tb_ring_row_scanner;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic       dir_ccw = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_bank = 1'b0;
    logic [2:0] wr_row = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] row_data;
    logic       cnt_step;
    logic       cnt_reset;
    logic [2:0] row_idx;

    ring_row_scanner dut (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .dir_ccw(dir_ccw),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_data(wr_data),
        .row_data(row_data), .cnt_step(cnt_step), .cnt_reset(cnt_reset),
        .row_idx(row_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: phase 0 = counter reset, odd = row shown,
    // even non-zero = step after a row.
    int    ph = 0;
    int    fdir = 0;
    int    mem [2][8];
    int    vectors = 0;
    int    misses = 0;
    int    cycles = 0;
    bit    done = 0;
    string ctx = "R1";

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            ph = 0;
            fdir = 0;
            for (int b = 0; b < 2; b++)
                for (int r = 0; r < 8; r++) mem[b][r] = 0;
        end else begin
            if (wr_en) mem[wr_bank][wr_row] = int'(wr_data);
            if (scan_en) begin
                if (ph == 0) fdir = int'(dir_ccw);
                ph = (ph + 1) % 16;
            end
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            vectors++;
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s/%s at cycle %0d: actual %0h expected %0h", tag, ctx, cycles, act, exp);
        end
    endtask

    task automatic compare();
        int e_data, e_idx, e_step, e_rst, r;
        string dtag;
        e_data = 0; e_step = 0; e_rst = 0; e_idx = 0; dtag = "R5";
        if (ph == 0) begin
            e_rst = 1;
        end else if (ph % 2 == 1) begin
            r = (ph - 1) / 2;
            e_idx = r;
            e_data = mem[fdir][r];
            dtag = "R6";
            if (r == 7) begin
                e_data = e_data & 15;   // R7 short row
                dtag = "R7";
            end
        end else begin
            e_idx = (ph - 2) / 2;
            e_step = 1;
        end
        chk(dtag,  int'(row_data),  e_data);
        chk("R10", int'(row_idx),   e_idx);
        chk("R4",  int'(cnt_step),  e_step);
        chk("R3",  int'(cnt_reset), e_rst);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    initial begin
        // R1: reset state
        ctx = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R2: no enable, nothing moves
        ctx = "R2";
        repeat (10) tick();

        // R9: load both banks, row 7 given a full byte to exercise R7
        ctx = "R9";
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < 8; r++) begin
                wr_en = 1'b1;
                wr_bank = 1'(b);
                wr_row = 3'(r);
                wr_data = (r == 7) ? 8'hFF : 8'((r * 37 + 5) ^ (b * 8'hA5));
                tick();
            end
        end
        wr_en = 1'b0;
        tick();

        // R8: direction flips mid-frame, takes effect only at next frame
        ctx = "R8";
        scan_en = 1'b1;
        for (int i = 0; i < 48; i++) begin
            if (i == 20) dir_ccw = 1'b1;
            if (i == 37) dir_ccw = 1'b0;
            tick();
        end

        // R2 and R9: sparse enable, random direction and writes
        ctx = "R9";
        for (int i = 0; i < 1500; i++) begin
            scan_en = ($urandom % 3) == 0;
            dir_ccw = 1'($urandom);
            wr_en = 1'($urandom);
            wr_bank = 1'($urandom);
            wr_row = 3'($urandom);
            wr_data = 8'($urandom);
            tick();
        end
        wr_en = 1'b0;

        // R6: continuous counter-clockwise frames
        ctx = "R6";
        scan_en = 1'b1;
        dir_ccw = 1'b1;
        repeat (32) tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule